// File: doc/BRIEF.md
# SD card clock divider programmer

This block turns a requested card clock frequency into a power-of-two divider code and loads that code into a card clock control register. The card clock is gated off during the whole update, so the card never sees a glitch. A request carries the source clock rate, the wanted frequency, a flag for the double-data-rate eMMC timing mode and a flag for whether an undivided clock may be selected. The block accepts the request only when it is idle. It starts from the source rate divided by 512 and doubles that clock once per cycle while the request is still at least twice the divided value. It then fixes up the code for the undivided case and writes the divider field. After that it re-enables the clock and pulses `done`.

Control is one state machine with six states. `ST_IDLE` moves to `ST_GATE_OFF` on *accept*. `ST_GATE_OFF` clears the enable bit. From there it goes to `ST_FINISH` on *zero request*, or to `ST_SEARCH` on *start search*. `ST_SEARCH` stays put on *double* and moves to `ST_WRITE_DIV` on *search exhausted*. `ST_WRITE_DIV` goes to `ST_GATE_ON` on *field written*. `ST_GATE_ON` goes to `ST_FINISH` on *clock restored*. `ST_FINISH` returns to `ST_IDLE` on *release*.

Top module: `sdclk_prog`

## Requirements
- R1: After reset, `busy`, `done`, `card_ctl`, `div_code` and `actual_rate` are all zero.
- R2: The search starts with a divided clock of `src_rate >> 9` and a code of 0x80000080. Each cycle it shifts the code right by one and doubles the divided clock, as long as `req_freq` is at least twice the divided clock and fewer than 9 shifts have been made.
- R3: When the accepted actual-clock flag is set and bit 22 of the code is set, the low 8 bits of the code are forced. They become 0xFF when the mode flag is low and 0x00 when it is high. In every other case the code is left unchanged.
- R4: The divider field of `card_ctl` changes only while the enable bit is low, both before and after the change. The enable bit is cleared before the field is written and set only after the write.
- R5: In `card_ctl`, bit 8 is the card clock enable and the divider field is mask 0xFFC000FF. When a non-zero request completes, the field equals `div_code`, the enable bit is 1 and `div_code` holds the fixed-up code.
- R6: A zero request clears the enable bit and leaves both the divider field and `div_code` unchanged. `actual_rate` reads 0.
- R7: After a non-zero request, `actual_rate` equals the accepted `src_rate`.
- R8: `done` is a one-cycle pulse. It appears k+4 clock edges after the accepting edge, where k is the number of shifts, or 1 edge after it for a zero request.
- R9: `busy` rises only on the edge after a request is accepted. A request that arrives while `busy` or `done` is high is ignored and produces no second result.
- R10: `done` and `busy` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only in idle |
| req_freq | input | 32 | Requested card clock frequency, 0 stops the clock |
| src_rate | input | 32 | Source clock rate |
| hs400_mode | input | 1 | Double-data-rate eMMC timing mode |
| actual_clk_en | input | 1 | Undivided clock selection permitted |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| div_code | output | 32 | Resulting divider code |
| actual_rate | output | 32 | Reported card clock source rate, 0 when stopped |
| card_ctl | output | 32 | Card clock control register image |

## Verification
Every result is due at a fixed edge count after the accepting edge. That count is k+4 for a request that needs k doublings and 1 for a zero request. All result ports settle by the edge that raises `done`. The driver computes k from the requirements alone and stores the expected latency with each expected item. The monitor keeps a running edge counter and samples on falling edges, when `done` is seen. It compares the measured latency and all result ports with the head of the queue. Any `done` that arrives with an empty queue is reported, and this is how ignored requests are checked.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE_OFF,
        ST_SEARCH,
        ST_WRITE_DIV,
        ST_GATE_ON,
        ST_FINISH
    } sdclk_state_e;

    localparam logic [31:0] SEED_CODE  = 32'h8000_0080;
    localparam int          PRE_SHIFT  = 9;
    localparam int          MAX_SHIFT  = 9;
    localparam int          FIX_BIT    = 22;
    localparam int          LOW_W      = 8;
    localparam int          EN_BIT     = 8;
    localparam logic [31:0] DIV_MASK   = 32'hFFC0_00FF;

endpackage

// File: rtl/sdclk_div_search.sv
module sdclk_div_search #(
    parameter int          DATA_W    = 32,
    parameter int          CODE_W    = 32,
    parameter logic [CODE_W-1:0] SEED = '0,
    parameter int          PRE_SHIFT = 9,
    parameter int          MAX_SHIFT = 9,
    localparam int         ITER_W    = $clog2(MAX_SHIFT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] src_in,
    input  logic [DATA_W-1:0] target,
    input  logic              step,
    output logic              cont,
    output logic [CODE_W-1:0] code
);

    logic [DATA_W-1:0] divided;
    logic [ITER_W-1:0] iter;

    // One comparison per cycle; the widened compare keeps the doubled value exact.
    always_comb begin
        cont = (iter < ITER_W'(MAX_SHIFT)) &&
               ({1'b0, target} >= {divided, 1'b0});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divided <= '0;
            iter    <= '0;
            code    <= '0;
        end else if (load) begin
            divided <= src_in >> PRE_SHIFT;
            iter    <= '0;
            code    <= SEED;
        end else if (step) begin
            divided <= divided << 1;
            iter    <= iter + 1'b1;
            code    <= code >> 1;
        end
    end

endmodule

// File: rtl/sdclk_code_fix.sv
module sdclk_code_fix #(
    parameter int CODE_W  = 32,
    parameter int FIX_BIT = 22,
    parameter int LOW_W   = 8
) (
    input  logic [CODE_W-1:0] raw,
    input  logic              ddr_mode,
    input  logic              undiv_ok,
    output logic [CODE_W-1:0] fixed
);

    always_comb begin
        fixed = raw;
        if (undiv_ok && raw[FIX_BIT]) begin
            fixed[LOW_W-1:0] = ddr_mode ? {LOW_W{1'b0}} : {LOW_W{1'b1}};
        end
    end

endmodule

// File: rtl/sdclk_ctl_reg.sv
module sdclk_ctl_reg #(
    parameter int                CTL_W    = 32,
    parameter int                EN_BIT   = 8,
    parameter logic [CTL_W-1:0]  DIV_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_off,
    input  logic             wr_div,
    input  logic [CTL_W-1:0] div_val,
    input  logic             gate_on,
    output logic [CTL_W-1:0] ctl
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (gate_off) begin
            ctl[EN_BIT] <= 1'b0;
        end else if (wr_div) begin
            ctl <= (ctl & ~DIV_MASK) | (div_val & DIV_MASK);
        end else if (gate_on) begin
            ctl[EN_BIT] <= 1'b1;
        end
    end

endmodule

// File: rtl/sdclk_prog.sv
module sdclk_prog
    import sdclk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTL_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_freq,
    input  logic [DATA_W-1:0] src_rate,
    input  logic              hs400_mode,
    input  logic              actual_clk_en,
    output logic              busy,
    output logic              done,
    output logic [CTL_W-1:0]  div_code,
    output logic [DATA_W-1:0] actual_rate,
    output logic [CTL_W-1:0]  card_ctl
);

    sdclk_state_e state, state_nx;

    logic [DATA_W-1:0] lat_freq;
    logic [DATA_W-1:0] lat_src;
    logic              lat_hs;
    logic              lat_act;
    logic              accept;
    logic              srch_load;
    logic              srch_step;
    logic              srch_cont;
    logic              do_gate_off;
    logic              do_wr_div;
    logic              do_gate_on;
    logic [CTL_W-1:0]  raw_code;
    logic [CTL_W-1:0]  fixed_code;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state and outputs
    always_comb begin
        state_nx    = state;
        accept      = 1'b0;
        srch_load   = 1'b0;
        srch_step   = 1'b0;
        do_gate_off = 1'b0;
        do_wr_div   = 1'b0;
        do_gate_on  = 1'b0;
        busy        = 1'b0;
        done        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept    = 1'b1;
                    srch_load = 1'b1;
                    state_nx  = ST_GATE_OFF;
                end
            end
            ST_GATE_OFF: begin
                busy        = 1'b1;
                do_gate_off = 1'b1;
                state_nx    = (lat_freq == '0) ? ST_FINISH : ST_SEARCH;
            end
            ST_SEARCH: begin
                busy = 1'b1;
                if (srch_cont) srch_step = 1'b1;
                else           state_nx  = ST_WRITE_DIV;
            end
            ST_WRITE_DIV: begin
                busy      = 1'b1;
                do_wr_div = 1'b1;
                state_nx  = ST_GATE_ON;
            end
            ST_GATE_ON: begin
                busy       = 1'b1;
                do_gate_on = 1'b1;
                state_nx   = ST_FINISH;
            end
            ST_FINISH: begin
                done     = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Request capture and reported values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_freq    <= '0;
            lat_src     <= '0;
            lat_hs      <= 1'b0;
            lat_act     <= 1'b0;
            div_code    <= '0;
            actual_rate <= '0;
        end else begin
            if (accept) begin
                lat_freq <= req_freq;
                lat_src  <= src_rate;
                lat_hs   <= hs400_mode;
                lat_act  <= actual_clk_en;
            end
            if (do_gate_off) begin
                actual_rate <= (lat_freq == '0) ? '0 : lat_src;
            end
            if (do_wr_div) begin
                div_code <= fixed_code;
            end
        end
    end

    sdclk_div_search #(
        .DATA_W    (DATA_W),
        .CODE_W    (CTL_W),
        .SEED      (CTL_W'(SEED_CODE)),
        .PRE_SHIFT (PRE_SHIFT),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_search (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (srch_load),
        .src_in (src_rate),
        .target (lat_freq),
        .step   (srch_step),
        .cont   (srch_cont),
        .code   (raw_code)
    );

    sdclk_code_fix #(
        .CODE_W  (CTL_W),
        .FIX_BIT (FIX_BIT),
        .LOW_W   (LOW_W)
    ) u_fix (
        .raw      (raw_code),
        .ddr_mode (lat_hs),
        .undiv_ok (lat_act),
        .fixed    (fixed_code)
    );

    sdclk_ctl_reg #(
        .CTL_W    (CTL_W),
        .EN_BIT   (EN_BIT),
        .DIV_MASK (CTL_W'(DIV_MASK))
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_off (do_gate_off),
        .wr_div   (do_wr_div),
        .div_val  (fixed_code),
        .gate_on  (do_gate_on),
        .ctl      (card_ctl)
    );

endmodule

// File: rtl/sdclk_prog_chk.sv
module sdclk_prog_chk #(
    parameter int               DATA_W   = 32,
    parameter int               CTL_W    = 32,
    parameter int               EN_BIT   = 8,
    parameter int               FIX_BIT  = 22,
    parameter logic [CTL_W-1:0] DIV_MASK = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [CTL_W-1:0]  div_code,
    input logic [CTL_W-1:0]  card_ctl,
    input logic [DATA_W-1:0] lat_freq,
    input logic              lat_hs,
    input logic              lat_act
);

    // R4
    field_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((card_ctl & DIV_MASK) != $past(card_ctl & DIV_MASK))
            |-> (!card_ctl[EN_BIT] && !$past(card_ctl[EN_BIT])));

    // R4
    enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_ctl[EN_BIT]) |-> $stable(card_ctl & DIV_MASK));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R6
    zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_freq == '0) |-> !card_ctl[EN_BIT]);

    // R5
    run_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_freq != '0) |-> (card_ctl[EN_BIT] &&
            ((card_ctl & DIV_MASK) == (div_code & DIV_MASK))));

    // R3
    fix_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_freq != '0 && lat_act && !lat_hs && div_code[FIX_BIT])
            |-> (div_code[7:0] == 8'hFF));

    // R3
    fix_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_freq != '0 && lat_act && lat_hs && div_code[FIX_BIT])
            |-> (div_code[7:0] == 8'h00));

endmodule

bind sdclk_prog sdclk_prog_chk #(
    .DATA_W   (DATA_W),
    .CTL_W    (CTL_W),
    .EN_BIT   (sdclk_pkg::EN_BIT),
    .FIX_BIT  (sdclk_pkg::FIX_BIT),
    .DIV_MASK (CTL_W'(sdclk_pkg::DIV_MASK))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .div_code  (div_code),
    .card_ctl  (card_ctl),
    .lat_freq  (lat_freq),
    .lat_hs    (lat_hs),
    .lat_act   (lat_act)
);

// File: tb/sdclk_prog_bench.sv
module sdclk_prog_bench;

    localparam logic [31:0] MASK = 32'hFFC0_00FF;
    localparam int          ENB  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_freq = '0;
    logic [31:0] src_rate = '0;
    logic        hs400_mode = 1'b0;
    logic        actual_clk_en = 1'b0;
    logic        busy;
    logic        done;
    logic [31:0] div_code;
    logic [31:0] actual_rate;
    logic [31:0] card_ctl;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int pushes = 0;
    int dones = 0;

    typedef struct {
        logic [31:0] code;
        logic [31:0] rate;
        logic [31:0] ctl;
        int          lat;
        int          acc;
    } exp_t;

    exp_t q[$];
    logic [31:0] m_code = '0;
    logic [31:0] m_ctl  = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdclk_prog u_sdclk_prog (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_freq      (req_freq),
        .src_rate      (src_rate),
        .hs400_mode    (hs400_mode),
        .actual_clk_en (actual_clk_en),
        .busy          (busy),
        .done          (done),
        .div_code      (div_code),
        .actual_rate   (actual_rate),
        .card_ctl      (card_ctl)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    // Expected result from the requirements (R2, R3, R5, R6, R7, R8)
    function automatic exp_t model(input logic [31:0] src, input logic [31:0] req,
                                   input logic hs, input logic act);
        exp_t e;
        longint unsigned d;
        int k;
        logic [31:0] c;
        if (req == 0) begin
            e.code = m_code;
            e.rate = 0;
            e.ctl  = m_ctl & ~(32'h1 << ENB);
            e.lat  = 1;
        end else begin
            d = longint'(src >> 9);
            k = 0;
            while (k < 9 && longint'(req) >= 2 * d) begin
                d = d * 2;
                k++;
            end
            c = 32'h8000_0080 >> k;
            if (act && c[22]) c[7:0] = hs ? 8'h00 : 8'hFF;
            e.code = c;
            e.rate = src;
            e.ctl  = (m_ctl & ~MASK) | (c & MASK) | (32'h1 << ENB);
            e.lat  = k + 4;
        end
        e.acc = 0;
        return e;
    endfunction

    task automatic send(input logic [31:0] src, input logic [31:0] req,
                        input logic hs, input logic act, input bit pester);
        exp_t e;
        @(negedge clk);
        while (busy || done) @(negedge clk);
        src_rate = src; req_freq = req; hs400_mode = hs; actual_clk_en = act;
        req_valid = 1'b1;
        e = model(src, req, hs, act);
        m_code = e.code;
        m_ctl  = e.ctl;
        @(negedge clk);
        e.acc = cyc;
        q.push_back(e);
        pushes++;
        if (pester) begin
            // R9: requests during busy and during done are ignored
            chk("R9 busy after accept", {31'b0, busy}, 32'd1);
            req_freq = ~req;
            src_rate = src ^ 32'h0F0F_0000;
            hs400_mode = ~hs;
            actual_clk_en = ~act;
            repeat (e.lat + 1) @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            dones++;
            if (q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R9 unexpected done actual=1 expected=0");
            end else begin
                e = q.pop_front();
                chk("R8 latency", 32'(cyc - e.acc), 32'(e.lat));
                chk("R2/R3 div_code", div_code, e.code);
                chk("R7/R6 actual_rate", actual_rate, e.rate);
                chk("R5/R6 card_ctl", card_ctl, e.ctl);
                chk("R10 busy low at done", {31'b0, busy}, 32'd0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 card_ctl", card_ctl, 32'd0);
        chk("R1 div_code", div_code, 32'd0);
        chk("R1 actual_rate", actual_rate, 32'd0);

        // R2: slowest code, no doubling
        send(200_000_000, 400_000, 1'b0, 1'b1, 1'b0);
        // R2: several doublings
        send(200_000_000, 25_000_000, 1'b0, 1'b0, 1'b0);
        // R6: zero request
        send(200_000_000, 0, 1'b0, 1'b0, 1'b0);
        // R2: divide by two, bit 22 clear so R3 fix inactive
        send(200_000_000, 100_000_000, 1'b0, 1'b1, 1'b0);
        // R3: undivided, low byte forced high
        send(200_000_000, 200_000_000, 1'b0, 1'b1, 1'b0);
        // R3: undivided in HS400 mode, low byte cleared
        send(200_000_000, 200_000_000, 1'b1, 1'b1, 1'b0);
        // R3: undivided without actual-clock support
        send(200_000_000, 200_000_000, 1'b0, 1'b0, 1'b0);
        // R2: cap at 9 shifts for huge request
        send(50_000_000, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0);
        // R2: small source, one doubling
        send(1000, 3, 1'b0, 1'b0, 1'b0);
        // R9: pester while busy and during done
        send(200_000_000, 12_000_000, 1'b0, 1'b0, 1'b1);
        send(200_000_000, 0, 1'b0, 1'b0, 1'b1);
        send(100_000_000, 52_000_000, 1'b1, 1'b1, 1'b0);

        repeat (30) @(negedge clk);
        // R9: exactly one result per accepted request
        chk("R9 result count", 32'(dones), 32'(pushes));
        chk("R9 queue drained", 32'(q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule